// File: doc/BRIEF.md
# Password-Guarded Peripheral Clock Divider

This block produces a divided clock-enable pulse for a peripheral. It picks one of several source clock-enable inputs and divides its tick rate by an integer held in a divisor register. Software talks to it through a small register port with two words: a control word holding the source selector, a run enable and a read-only busy flag, and a divisor word. Every write must carry a fixed password in its top byte. A write without the password changes nothing.

Source and divisor may be changed only while the block is idle. Clearing the run enable asks the output to stop. The output keeps running until the current output period has finished, so no shortened pulse ever appears. Busy stays high until that point. The intended software sequence is: write the source with the enable low, write the divisor, then write the same source again with the enable set. To stop, clear the enable and poll busy until it reads low.

Top module: `pclk_divider`

## Requirements
- R1: After reset the control word reads 0 (enable low, busy low, source 0) and the divisor field reads 1.
- R2: A write whose bits [31:24] differ from the password 0xA5 changes no register, whichever word it targets.
- R3: Address 0 is the control word: source select in bits [1:0], run enable in bit 4 (read/write), busy in bit 7 (read only). Address 1 is the divisor word, with the divisor in bits [23:12]. All other read bits are 0.
- R4: With divisor N ≥ 2, the output pulses on every Nth tick of the selected source. Counting starts with the ticks that arrive from the second cycle after the write that set the enable, and the first pulse falls on the Nth such tick.
- R5: A divisor of 0 or 1 passes each tick of the selected source straight to the output while running.
- R6: The output follows only the source input whose index equals the source select field.
- R7: After the enable is cleared, busy stays high until the final pulse of the current period has been emitted, and it reads low from the cycle after that pulse.
- R8: Busy is high whenever the enable is set or the output is still running. While busy is high, the source field and the whole divisor word ignore writes, but the enable bit still accepts them.
- R9: Setting the enable again before a requested stop completes cancels the stop; busy never drops and the pulse spacing continues unchanged.
- R10: No output pulse occurs while busy reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Word select: 0 control, 1 divisor |
| regWdata | input | 32 | Write data, password in the top byte |
| regRdata | output | 32 | Read data of the addressed word, combinational |
| srcEn | input | 4 | Per-source tick inputs |
| clkEnOut | output | 1 | Divided clock-enable pulse |

## Verification
The bench builds the block with its defaults: four sources, a 12-bit divisor and password 0xA5. The sources tick at different rates: one every cycle, one every third cycle, one at random and one every fifth cycle. Against these, a behavioural model checks the pulse stream and the read data on every cycle. The patterns bring within reach the passthrough divisors 0 and 1, sparse-source periods, a stop that has to wait many cycles for a period end, a stop cancelled mid-period, and writes that are rejected for a wrong password or because busy is high.

// File: rtl/pclkdiv_pkg.sv
`timescale 1ns/1ps
package pclkdiv_pkg;

  // Word addresses of the register port
  localparam logic CTRL_WORD = 1'b0;
  localparam logic DIV_WORD  = 1'b1;

  // Bit positions inside the control word and divisor word
  localparam int ENABLE_BIT = 4;
  localparam int BUSY_BIT   = 7;
  localparam int DIV_LSB    = 12;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic runOn;     // output pulses allowed
    logic cntClear;  // hold the period counter at zero
  } divStrobe_t;

endpackage

// File: rtl/pclkdiv_ctrl.sv
`timescale 1ns/1ps
module pclkdiv_ctrl
  import pclkdiv_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          PWD_W   = 8,
  parameter logic [7:0]  PWD_VAL = 8'hA5,
  parameter int          DIV_W   = 12,
  parameter int          SRC_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              periodEnd,
  output divStrobe_t        strobe,
  output logic [SRC_W-1:0]  srcSel,
  output logic [DIV_W-1:0]  divVal,
  output logic              enableQ,
  output logic              busy
);

  localparam int PWD_LSB = DATA_W - PWD_W;

  logic pwdOk;
  logic ctrlWr;
  logic divWr;
  logic running;
  logic unusedWdata;

  assign pwdOk  = (regWdata[PWD_LSB +: PWD_W] == PWD_VAL[PWD_W-1:0]);
  assign ctrlWr = regWe && pwdOk && (regAddr == CTRL_WORD);
  assign divWr  = regWe && pwdOk && (regAddr == DIV_WORD);
  assign busy   = enableQ | running;
  assign unusedWdata = ^regWdata;

  // Software-visible fields
  always_ff @(posedge clk) begin
    if (rst) begin
      enableQ <= 1'b0;
      srcSel  <= '0;
      divVal  <= DIV_W'(1);
    end else begin
      if (ctrlWr) begin
        enableQ <= regWdata[ENABLE_BIT];
        if (!busy) srcSel <= regWdata[SRC_W-1:0];
      end
      if (divWr && !busy) divVal <= regWdata[DIV_LSB +: DIV_W];
    end
  end

  // Run state: starts one cycle after enable, stops only at a period end
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else if (!running) begin
      running <= enableQ;
    end else if (!enableQ && periodEnd) begin
      running <= 1'b0;
    end
  end

  always_comb begin
    strobe.runOn    = running;
    strobe.cntClear = !running;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_WORD) begin
      regRdata[BUSY_BIT]    = busy;
      regRdata[ENABLE_BIT]  = enableQ;
      regRdata[SRC_W-1:0]   = srcSel;
    end else begin
      regRdata[DIV_LSB +: DIV_W] = divVal;
    end
  end

endmodule

// File: rtl/pclkdiv_path.sv
`timescale 1ns/1ps
module pclkdiv_path
  import pclkdiv_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2,
  parameter int DIV_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [SRC_W-1:0]   srcSel,
  input  logic [DIV_W-1:0]   divVal,
  input  divStrobe_t         strobe,
  output logic               periodEnd,
  output logic               clkEnOut
);

  logic             tick;
  logic [DIV_W-1:0] lastCnt;
  logic [DIV_W-1:0] cnt;

  // Source selection; out-of-range selector yields no ticks
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(srcSel) == i) tick = srcEn[i];
    end
  end

  // Divisors 0 and 1 both mean one tick per period
  assign lastCnt   = (divVal < DIV_W'(2)) ? '0 : divVal - DIV_W'(1);
  assign periodEnd = tick && (cnt == lastCnt);
  assign clkEnOut  = strobe.runOn && periodEnd;

  always_ff @(posedge clk) begin
    if (rst || strobe.cntClear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= periodEnd ? '0 : cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/pclk_divider.sv
`timescale 1ns/1ps
module pclk_divider
  import pclkdiv_pkg::*;
#(
  parameter int         NUM_SRC = 4,
  parameter int         DIV_W   = 12,
  parameter int         DATA_W  = 32,
  parameter int         PWD_W   = 8,
  parameter logic [7:0] PWD_VAL = 8'hA5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               regWe,
  input  logic               regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] srcEn,
  output logic               clkEnOut
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  divStrobe_t       strobe;
  logic             periodEnd;
  logic [SRC_W-1:0] srcSel;
  logic [DIV_W-1:0] divVal;
  logic             enableQ;
  logic             busy;

  pclkdiv_ctrl #(
    .DATA_W (DATA_W),
    .PWD_W  (PWD_W),
    .PWD_VAL(PWD_VAL),
    .DIV_W  (DIV_W),
    .SRC_W  (SRC_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .periodEnd(periodEnd),
    .strobe   (strobe),
    .srcSel   (srcSel),
    .divVal   (divVal),
    .enableQ  (enableQ),
    .busy     (busy)
  );

  pclkdiv_path #(
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W),
    .DIV_W  (DIV_W)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .srcEn    (srcEn),
    .srcSel   (srcSel),
    .divVal   (divVal),
    .strobe   (strobe),
    .periodEnd(periodEnd),
    .clkEnOut (clkEnOut)
  );

endmodule

// File: rtl/pclkdiv_chk.sv
`timescale 1ns/1ps
module pclkdiv_chk #(
  parameter int         DATA_W  = 32,
  parameter int         PWD_W   = 8,
  parameter logic [7:0] PWD_VAL = 8'hA5,
  parameter int         DIV_W   = 12,
  parameter int         SRC_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              regWe,
  input logic [DATA_W-1:0] regWdata,
  input logic              clkEnOut,
  input logic              busyQ,
  input logic              enableQ,
  input logic [DIV_W-1:0]  divVal,
  input logic [SRC_W-1:0]  srcSel
);

  // R10
  pulse_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    clkEnOut |-> busyQ);

  // R7
  clean_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busyQ) |-> $past(clkEnOut));

  // R8
  div_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busyQ) |-> $stable(divVal));

  // R8
  src_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busyQ) |-> $stable(srcSel));

  // R2
  pwd_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (regWe && (regWdata[DATA_W-1 -: PWD_W] != PWD_VAL[PWD_W-1:0]))
      |=> ($stable(divVal) && $stable(srcSel) && $stable(enableQ)));

endmodule

bind pclk_divider pclkdiv_chk #(
  .DATA_W (DATA_W),
  .PWD_W  (PWD_W),
  .PWD_VAL(PWD_VAL),
  .DIV_W  (DIV_W),
  .SRC_W  (SRC_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .regWe   (regWe),
  .regWdata(regWdata),
  .clkEnOut(clkEnOut),
  .busyQ   (busy),
  .enableQ (enableQ),
  .divVal  (divVal),
  .srcSel  (srcSel)
);

// File: tb/tb_pclk_divider.sv
`timescale 1ns/1ps
module tb_pclk_divider;

  localparam logic [31:0] PWD = 32'hA500_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWe = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [3:0]  srcEn = '0;
  logic [31:0] regRdata;
  logic        clkEnOut;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pulses = 0;

  // behavioural model state
  bit mEn, mRun;
  int mSrc, mDiv, mCnt;

  pclk_divider dut (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .srcEn(srcEn),
    .clkEnOut(clkEnOut)
  );

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mLast();
    return (mDiv < 2) ? 0 : mDiv - 1;
  endfunction

  function automatic bit mBusy();
    return mEn || mRun;
  endfunction

  function automatic logic [31:0] mRead(logic a);
    if (a == 1'b0) return (32'(mBusy()) << 7) | (32'(mEn) << 4) | 32'(mSrc);
    return 32'(mDiv) << 12;
  endfunction

  // reference model, advanced once per rising edge
  always @(posedge clk) begin
    if (rst) begin
      mEn = 0; mRun = 0; mSrc = 0; mDiv = 1; mCnt = 0;
    end else begin
      bit tk, pend, wasBusy, nEn, nRun;
      tk = srcEn[mSrc];
      pend = tk && (mCnt == mLast());
      wasBusy = mBusy();
      nEn = mEn;
      nRun = mRun;
      if (!mRun) begin
        nRun = mEn;
        mCnt = 0;
      end else begin
        if (tk) mCnt = pend ? 0 : mCnt + 1;
        if (!mEn && pend) nRun = 0;
      end
      if (regWe && regWdata[31:24] == 8'hA5) begin
        if (regAddr == 1'b0) begin
          nEn = regWdata[4];
          if (!wasBusy) mSrc = int'(regWdata[1:0]);
        end else if (!wasBusy) begin
          mDiv = int'(regWdata[23:12]);
        end
      end
      mEn = nEn;
      mRun = nRun;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      bit expOut;
      expOut = mRun && srcEn[mSrc] && (mCnt == mLast());
      chk(clkEnOut === expOut, "R4 R5 R6 R9 R10 pulse", 32'(clkEnOut), 32'(expOut));
      chk(regRdata === mRead(regAddr), "R3 R7 R8 readback", regRdata, mRead(regAddr));
      if (clkEnOut) pulses++;
    end
  end

  // source tick patterns
  always @(negedge clk) begin
    #1;
    cyc++;
    srcEn[0] = 1'b1;
    srcEn[1] = (cyc % 3 == 0);
    srcEn[2] = 1'($urandom % 2);
    srcEn[3] = (cyc % 5 == 0);
  end

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk); #1;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(logic a, output logic [31:0] v);
    @(negedge clk); #1;
    regAddr = a;
    @(negedge clk);
    v = regRdata;
  endtask

  task automatic stopWait(int src, output int polls);
    logic [31:0] v;
    wr(1'b0, PWD | 32'(src));
    polls = 0;
    do begin
      rd(1'b0, v);
      polls++;
    end while (v[7] && polls < 20000);
  endtask

  task automatic window(int n, output int cnt);
    int p0;
    p0 = pulses;
    repeat (n) @(negedge clk);
    cnt = pulses - p0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, polls, p0;
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(1'b0, v); chk(v == 32'h0, "R1 control after reset", v, 32'h0);
    rd(1'b1, v); chk(v == 32'h1000, "R1 R3 divisor after reset", v, 32'h1000);

    // R2 missing or wrong password
    wr(1'b1, 32'h0000_4000);
    rd(1'b1, v); chk(v == 32'h1000, "R2 divisor without password", v, 32'h1000);
    wr(1'b0, 32'h5A00_0013);
    rd(1'b0, v); chk(v == 32'h0, "R2 control with wrong password", v, 32'h0);

    // R4 divide source 1 (every 3rd cycle) by 4
    wr(1'b1, PWD | (32'd4 << 12));
    wr(1'b0, PWD | 32'd1);
    wr(1'b0, PWD | 32'h11);
    rd(1'b0, v); chk(v == 32'h91, "R3 R8 busy enable source readback", v, 32'h91);
    window(120, n); chk(n >= 9 && n <= 11, "R4 pulses per 120 cycles", 32'(n), 32'd10);

    // R8 writes to divisor and source ignored while busy
    wr(1'b1, PWD | (32'd7 << 12));
    rd(1'b1, v); chk(v == 32'h4000, "R8 divisor write while busy", v, 32'h4000);
    wr(1'b0, PWD | 32'h12);
    rd(1'b0, v); chk(v == 32'h91, "R8 source write while busy", v, 32'h91);

    // R7 clean stop, R10 silence afterwards
    p0 = pulses;
    stopWait(1, polls);
    chk(polls < 20000, "R7 busy clears", 32'(polls), 32'd0);
    chk(pulses > p0, "R7 final pulse before idle", 32'(pulses - p0), 32'd1);
    window(40, n); chk(n == 0, "R10 no pulses when idle", 32'(n), 32'd0);

    // R5 passthrough with divisor 0 on source 0
    wr(1'b1, PWD);
    wr(1'b0, PWD);
    wr(1'b0, PWD | 32'h10);
    repeat (2) @(negedge clk);
    window(20, n); chk(n == 20, "R5 divisor 0 passthrough", 32'(n), 32'd20);
    stopWait(0, polls);

    // R5 divisor 1 on source 3 (every 5th cycle), R6 selection
    wr(1'b1, PWD | (32'd1 << 12));
    wr(1'b0, PWD | 32'd3);
    wr(1'b0, PWD | 32'h13);
    repeat (2) @(negedge clk);
    window(50, n); chk(n == 10, "R5 R6 divisor 1 on source 3", 32'(n), 32'd10);
    stopWait(3, polls);

    // R9 stop cancelled by re-enable, divisor 6 on source 0
    wr(1'b1, PWD | (32'd6 << 12));
    wr(1'b0, PWD);
    wr(1'b0, PWD | 32'h10);
    repeat (8) @(negedge clk);
    wr(1'b0, PWD);
    wr(1'b0, PWD | 32'h10);
    rd(1'b0, v); chk(v == 32'h90, "R9 busy held after cancel", v, 32'h90);
    window(60, n); chk(n == 10, "R9 spacing unchanged", 32'(n), 32'd10);
    stopWait(0, polls);

    // R6 random source 2, divisor 3 (model compares each cycle)
    wr(1'b1, PWD | (32'd3 << 12));
    wr(1'b0, PWD | 32'd2);
    wr(1'b0, PWD | 32'h12);
    window(300, n); chk(n > 20, "R6 source 2 produces pulses", 32'(n), 32'd50);
    stopWait(2, polls);

    // R4 largest divisor on source 0
    wr(1'b1, PWD | (32'hFFF << 12));
    wr(1'b0, PWD | 32'h10);
    window(4095 + 4, n); chk(n == 1, "R4 divisor 4095 one pulse", 32'(n), 32'd1);
    stopWait(0, polls);
    chk(polls < 20000, "R7 stop at divisor 4095", 32'(polls), 32'd0);

    summary();
    $finish;
  end

endmodule